// File: doc/BRIEF.md
# Multiply Stage with Range Guard and Fractional Scaling

This block is the front end of a multiply-accumulate unit. Each accepted operand pair is multiplied in one of three modes: signed integer, unsigned integer or fractional. The 64-bit product is then shaped for a 40-bit accumulator. Integer products are checked against the accumulator range. When a product does not fit, the block raises a one-cycle overflow pulse, and the status logic downstream ORs that pulse into its sticky overflow bit.

Two control bits travel with each operand pair. The saturate bit decides what happens to an integer product that does not fit. When the bit is clear, the product is wrapped to 40 bits. When it is set, the product is replaced by a sentinel of magnitude 2^50, which is large enough that the following accumulate is sure to overflow. The round bit applies only in fractional mode. There the product is scaled down by 24 bits, and when the round bit is set the result is rounded half-to-even using the bits that were dropped.

The block is a two-stage pipeline. The first stage multiplies and the second stage conditions the product. A valid flag travels with the data through both stages. There is no backpressure: a new pair may be accepted in every cycle.

Top module: `mac_mul_stage`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid`, `ovf_pulse` and `out_prod` are all zero. Operands presented during reset produce no result.
- R2: A pair accepted with `in_valid` high appears on `out_prod` with `out_valid` high exactly two clock edges later. Pairs on consecutive cycles give results on consecutive cycles, in the same order.
- R3: Mode code 0 is signed integer. The operands are multiplied as two's complement values. When the product equals its own sign extension from bit 39, the output is the full product and `ovf_pulse` stays low.
- R4: In signed mode, a product that is not equal to its sign extension from bit 39 raises `ovf_pulse`. With `sat_en` low, the output is bits 39..0 sign-extended to 64 bits.
- R5: In signed mode with overflow and `sat_en` high, the output is 2^50 (0x0004_0000_0000_0000) for a non-negative product. For a negative product it is the bitwise inverse of that value (0xFFFB_FFFF_FFFF_FFFF).
- R6: Mode code 1 is unsigned integer. The operands are multiplied as unsigned values. `ovf_pulse` rises when any of product bits 63..40 is set. With `sat_en` low, the output is bits 39..0 zero-extended.
- R7: In unsigned mode with overflow and `sat_en` high, the output is 2^50.
- R8: Mode code 2 is fractional. The signed product is shifted right arithmetically by 24 bits, and `ovf_pulse` never rises, whatever the value of `sat_en`.
- R9: In fractional mode with `rnd_en` high, the shifted value is incremented when the 24 dropped bits exceed 0x800000. When the dropped bits equal 0x800000, it is incremented only if the shifted value is odd. Otherwise the value is left unchanged.
- R10: `ovf_pulse` is high only in a cycle where `out_valid` is high. Each overflowing pair gives a pulse exactly one cycle long.
- R11: Mode code 3 behaves exactly like mode code 2.
- R12: `rnd_en` has no effect in either integer mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair present this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| mode | input | 2 | 0 signed, 1 unsigned, 2 or 3 fractional |
| sat_en | input | 1 | Replace overflowing integer products with the 2^50 sentinel |
| rnd_en | input | 1 | Round-half-to-even in fractional mode |
| out_valid | output | 1 | Conditioned product valid |
| out_prod | output | 64 | Conditioned product |
| ovf_pulse | output | 1 | One-cycle overflow indication |

## Verification
The bench steps across the 40-bit boundary in both integer modes. In signed mode it uses -2^39, which fits, and +2^39, which does not. In unsigned mode it uses a product that fills exactly 40 bits and one that is 2^40. A guard that uses the wrong bit index would flag one of these pairs wrongly, and a design that compared magnitudes without sign extension would wrap -2^39 into a positive value.

The rounding cases cover exact halves with both an even and an odd shifted value, values one below and one above half, and a negative half. A design that always rounded half up, or that took the remainder of a logical shift, gives a result one off in at least one of these cases.

Saturation is driven with products of both signs, to catch a sentinel whose polarity is inverted. A pipeline test with mixed modes and consecutive pairs catches results that come out late or in the wrong order.

// File: rtl/mac_mul_pkg.sv
package mac_mul_pkg;

    localparam int MM_OP_W     = 32;
    localparam int MM_ACC_W    = 40;
    localparam int MM_FRAC_SH  = 24;
    localparam int MM_SENT_POS = 50;

    typedef enum logic [1:0] {
        MM_SINT     = 2'd0,
        MM_UINT     = 2'd1,
        MM_FRAC     = 2'd2,
        MM_FRAC_ALT = 2'd3
    } mm_mode_e;

    typedef struct packed {
        logic     valid;
        mm_mode_e mode;
        logic     sat;
        logic     rnd;
    } mm_ctrl_t;

    function automatic logic mm_is_frac(mm_mode_e m);
        return m[1];
    endfunction

    function automatic logic mm_is_signed_mul(mm_mode_e m);
        return m != MM_UINT;
    endfunction

endpackage

// File: rtl/mac_mul_product.sv
module mac_mul_product
    import mac_mul_pkg::*;
#(
    parameter int OP_W = MM_OP_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  mm_ctrl_t              in_ctrl,
    input  logic [OP_W-1:0]       op_a,
    input  logic [OP_W-1:0]       op_b,
    output mm_ctrl_t              out_ctrl,
    output logic [2*OP_W-1:0]     prod
);
    localparam int PW = 2 * OP_W;

    logic          sgn;
    logic [PW-1:0] ext_a;
    logic [PW-1:0] ext_b;
    logic [PW-1:0] mul_res;

    assign sgn     = mm_is_signed_mul(in_ctrl.mode);
    assign ext_a   = {{OP_W{sgn & op_a[OP_W-1]}}, op_a};
    assign ext_b   = {{OP_W{sgn & op_b[OP_W-1]}}, op_b};
    assign mul_res = ext_a * ext_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_ctrl <= '0;
            prod     <= '0;
        end else begin
            out_ctrl <= in_ctrl;
            if (in_ctrl.valid) begin
                prod <= mul_res;
            end
        end
    end

    // R2
    stage_fill_chk: assert property (@(posedge clk) disable iff (rst)
        in_ctrl.valid |=> out_ctrl.valid);

    // R2
    stage_drain_chk: assert property (@(posedge clk) disable iff (rst)
        !in_ctrl.valid |=> !out_ctrl.valid);

endmodule

// File: rtl/mac_mul_int_guard.sv
module mac_mul_int_guard
    import mac_mul_pkg::*;
#(
    parameter int PW       = 2 * MM_OP_W,
    parameter int ACC_W    = MM_ACC_W,
    parameter int SENT_POS = MM_SENT_POS
) (
    input  logic [PW-1:0] prod,
    input  logic          is_signed,
    input  logic          sat,
    output logic [PW-1:0] value,
    output logic          ovf
);
    localparam int HI_W = PW - ACC_W;
    localparam logic [PW-1:0] POS_SENT = {{(PW-1){1'b0}}, 1'b1} << SENT_POS;
    localparam logic [PW-1:0] NEG_SENT = ~POS_SENT;

    logic [PW-1:0] sext;
    logic [PW-1:0] zext;
    logic          s_ovf;
    logic          u_ovf;

    assign sext  = {{HI_W{prod[ACC_W-1]}}, prod[ACC_W-1:0]};
    assign zext  = {{HI_W{1'b0}}, prod[ACC_W-1:0]};
    assign s_ovf = (sext != prod);
    assign u_ovf = |prod[PW-1:ACC_W];

    always_comb begin
        if (is_signed) begin
            ovf = s_ovf;
            if (s_ovf && sat) begin
                value = prod[PW-1] ? NEG_SENT : POS_SENT;
            end else begin
                value = sext;
            end
        end else begin
            ovf = u_ovf;
            if (u_ovf && sat) begin
                value = POS_SENT;
            end else begin
                value = zext;
            end
        end
    end

endmodule

// File: rtl/mac_mul_frac_scale.sv
module mac_mul_frac_scale
    import mac_mul_pkg::*;
#(
    parameter int PW      = 2 * MM_OP_W,
    parameter int FRAC_SH = MM_FRAC_SH
) (
    input  logic [PW-1:0] prod,
    input  logic          rnd,
    output logic [PW-1:0] value
);
    localparam logic [FRAC_SH-1:0] HALF = {1'b1, {(FRAC_SH-1){1'b0}}};

    logic [PW-1:0]      shifted;
    logic [FRAC_SH-1:0] rem;
    logic               bump;

    assign shifted = $signed(prod) >>> FRAC_SH;
    assign rem     = prod[FRAC_SH-1:0];
    assign bump    = rnd && ((rem > HALF) || ((rem == HALF) && shifted[0]));
    assign value   = shifted + {{(PW-1){1'b0}}, bump};

endmodule

// File: rtl/mac_mul_stage.sv
module mac_mul_stage
    import mac_mul_pkg::*;
#(
    parameter int OP_W     = MM_OP_W,
    parameter int ACC_W    = MM_ACC_W,
    parameter int FRAC_SH  = MM_FRAC_SH,
    parameter int SENT_POS = MM_SENT_POS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [OP_W-1:0]       op_a,
    input  logic [OP_W-1:0]       op_b,
    input  logic [1:0]            mode,
    input  logic                  sat_en,
    input  logic                  rnd_en,
    output logic                  out_valid,
    output logic [2*OP_W-1:0]     out_prod,
    output logic                  ovf_pulse
);
    localparam int PW = 2 * OP_W;
    localparam logic [PW-1:0] POS_SENT = {{(PW-1){1'b0}}, 1'b1} << SENT_POS;

    mm_ctrl_t      in_ctrl;
    mm_ctrl_t      s1_ctrl;
    logic [PW-1:0] s1_prod;
    logic [PW-1:0] int_val;
    logic          int_ovf;
    logic [PW-1:0] frac_val;
    logic          s1_frac;
    logic          s1_signed;

    assign in_ctrl.valid = in_valid;
    assign in_ctrl.mode  = mm_mode_e'(mode);
    assign in_ctrl.sat   = sat_en;
    assign in_ctrl.rnd   = rnd_en;

    mac_mul_product #(.OP_W(OP_W)) u_product (
        .clk      (clk),
        .rst      (rst),
        .in_ctrl  (in_ctrl),
        .op_a     (op_a),
        .op_b     (op_b),
        .out_ctrl (s1_ctrl),
        .prod     (s1_prod)
    );

    assign s1_frac   = mm_is_frac(s1_ctrl.mode);
    assign s1_signed = (s1_ctrl.mode == MM_SINT);

    mac_mul_int_guard #(.PW(PW), .ACC_W(ACC_W), .SENT_POS(SENT_POS)) u_guard (
        .prod      (s1_prod),
        .is_signed (s1_signed),
        .sat       (s1_ctrl.sat),
        .value     (int_val),
        .ovf       (int_ovf)
    );

    mac_mul_frac_scale #(.PW(PW), .FRAC_SH(FRAC_SH)) u_frac (
        .prod  (s1_prod),
        .rnd   (s1_ctrl.rnd),
        .value (frac_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_prod  <= '0;
            ovf_pulse <= 1'b0;
        end else begin
            out_valid <= s1_ctrl.valid;
            ovf_pulse <= s1_ctrl.valid && !s1_frac && int_ovf;
            if (s1_ctrl.valid) begin
                out_prod <= s1_frac ? frac_val : int_val;
            end
        end
    end

    // R2
    result_latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    // R10
    ovf_only_valid_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> out_valid);

    // R8
    frac_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (s1_ctrl.valid && s1_frac) |=> !ovf_pulse);

    // R5
    sint_pos_sent_chk: assert property (@(posedge clk) disable iff (rst)
        (s1_ctrl.valid && s1_signed && s1_ctrl.sat && int_ovf && !s1_prod[PW-1])
        |=> (ovf_pulse && out_prod == POS_SENT));

    // R5
    sint_neg_sent_chk: assert property (@(posedge clk) disable iff (rst)
        (s1_ctrl.valid && s1_signed && s1_ctrl.sat && int_ovf && s1_prod[PW-1])
        |=> (ovf_pulse && out_prod == ~POS_SENT));

    // R7
    uint_sent_chk: assert property (@(posedge clk) disable iff (rst)
        (s1_ctrl.valid && s1_ctrl.mode == MM_UINT && s1_ctrl.sat && (|s1_prod[PW-1:ACC_W]))
        |=> (ovf_pulse && out_prod == POS_SENT));

endmodule

// File: tb/mac_mul_stage_tb_top.sv
`timescale 1ns/1ps
module mac_mul_stage_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [1:0]  mode = 2'd0;
    logic        sat_en = 1'b0;
    logic        rnd_en = 1'b0;
    logic        out_valid;
    logic [63:0] out_prod;
    logic        ovf_pulse;

    int n_checks = 0;
    int n_fail   = 0;

    localparam logic [63:0] SENT_P = 64'h0004_0000_0000_0000;
    localparam logic [63:0] SENT_N = 64'hFFFB_FFFF_FFFF_FFFF;

    always #2.5 clk = ~clk;

    mac_mul_stage dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .mode      (mode),
        .sat_en    (sat_en),
        .rnd_en    (rnd_en),
        .out_valid (out_valid),
        .out_prod  (out_prod),
        .ovf_pulse (ovf_pulse)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m,
                         input logic s, input logic r);
        in_valid = 1'b1; op_a = a; op_b = b; mode = m; sat_en = s; rnd_en = r;
    endtask

    task automatic run_case(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m,
                            input logic s, input logic r, input logic [63:0] exp_v,
                            input logic exp_o, input string tag);
        @(negedge clk);
        drive(a, b, m, s, r);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check({63'd0, out_valid}, 64'd1, {tag, " valid"});
        check(out_prod, exp_v, {tag, " value"});
        check({63'd0, ovf_pulse}, {63'd0, exp_o}, {tag, " ovf"});
        @(negedge clk);
        check({62'd0, out_valid, ovf_pulse}, 64'd0, {tag, " R10 idle after result"});
    endtask

    task automatic test_reset();
        @(negedge clk);
        drive(32'h4000_0000, 32'h4000_0000, 2'd1, 1'b1, 1'b0);
        @(negedge clk);
        check({62'd0, out_valid, ovf_pulse}, 64'd0, "R1 flags in reset");
        check(out_prod, 64'd0, "R1 value in reset");
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check({62'd0, out_valid, ovf_pulse}, 64'd0, "R1 flags after reset");
        check(out_prod, 64'd0, "R1 value after reset");
    endtask

    task automatic test_signed();
        run_case(32'd3, 32'hFFFF_FFFB, 2'd0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFF1, 1'b0, "R3 small negative");
        run_case(32'hFFF8_0000, 32'h0010_0000, 2'd0, 1'b0, 1'b0, 64'hFFFF_FF80_0000_0000, 1'b0, "R3 minus 2^39 fits");
        run_case(32'h0008_0000, 32'h0010_0000, 2'd0, 1'b0, 1'b0, 64'hFFFF_FF80_0000_0000, 1'b1, "R4 plus 2^39 wraps");
        run_case(32'h8000_0000, 32'h7FFF_FFFF, 2'd0, 1'b0, 1'b0, 64'h0000_0000_8000_0000, 1'b1, "R4 negative wraps");
        run_case(32'h0008_0000, 32'h0010_0000, 2'd0, 1'b1, 1'b0, SENT_P, 1'b1, "R5 positive sentinel");
        run_case(32'h8000_0000, 32'h7FFF_FFFF, 2'd0, 1'b1, 1'b0, SENT_N, 1'b1, "R5 negative sentinel");
        run_case(32'd3, 32'hFFFF_FFFB, 2'd0, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFF1, 1'b0, "R12 round ignored signed");
    endtask

    task automatic test_unsigned();
        run_case(32'hFFFF_FFFF, 32'h0000_0100, 2'd1, 1'b1, 1'b0, 64'h0000_00FF_FFFF_FF00, 1'b0, "R6 full 40 bits fits");
        run_case(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd1, 1'b0, 1'b0, 64'h0000_00FE_0000_0001, 1'b1, "R6 truncate");
        run_case(32'h8000_0000, 32'h0000_0200, 2'd1, 1'b0, 1'b0, 64'd0, 1'b1, "R6 exactly 2^40");
        run_case(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd1, 1'b1, 1'b0, SENT_P, 1'b1, "R7 sentinel");
        run_case(32'hFFFF_FFFF, 32'h0000_0100, 2'd1, 1'b0, 1'b1, 64'h0000_00FF_FFFF_FF00, 1'b0, "R12 round ignored unsigned");
    endtask

    task automatic test_frac();
        run_case(32'h0100_0000, 32'd3, 2'd2, 1'b0, 1'b0, 64'd3, 1'b0, "R8 exact scale");
        run_case(32'h0180_0000, 32'd1, 2'd2, 1'b0, 1'b0, 64'd1, 1'b0, "R8 truncate half");
        run_case(32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'd2, 1'b1, 1'b1, 64'h0000_003F_FFFF_FF00, 1'b0, "R8 large no ovf");
        run_case(32'h0180_0000, 32'd1, 2'd2, 1'b0, 1'b1, 64'd2, 1'b0, "R9 half odd rounds up");
        run_case(32'h0280_0000, 32'd1, 2'd2, 1'b0, 1'b1, 64'd2, 1'b0, "R9 half even stays");
        run_case(32'h0280_0001, 32'd1, 2'd2, 1'b0, 1'b1, 64'd3, 1'b0, "R9 above half");
        run_case(32'h027F_FFFF, 32'd1, 2'd2, 1'b0, 1'b1, 64'd2, 1'b0, "R9 below half");
        run_case(32'hFE80_0000, 32'd1, 2'd2, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, "R9 negative half");
        run_case(32'h0180_0000, 32'd1, 2'd3, 1'b0, 1'b1, 64'd2, 1'b0, "R11 alternate code rounds");
        run_case(32'h0180_0000, 32'd1, 2'd3, 1'b0, 1'b0, 64'd1, 1'b0, "R11 alternate code truncates");
    endtask

    task automatic test_stream();
        @(negedge clk);
        drive(32'd3, 32'hFFFF_FFFB, 2'd0, 1'b0, 1'b0);
        @(negedge clk);
        drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd1, 1'b0, 1'b0);
        @(negedge clk);
        drive(32'h0180_0000, 32'd1, 2'd2, 1'b0, 1'b1);
        check({63'd0, out_valid}, 64'd1, "R2 stream first valid");
        check(out_prod, 64'hFFFF_FFFF_FFFF_FFF1, "R2 stream first value");
        check({63'd0, ovf_pulse}, 64'd0, "R2 stream first ovf");
        @(negedge clk);
        in_valid = 1'b0;
        check({63'd0, out_valid}, 64'd1, "R2 stream second valid");
        check(out_prod, 64'h0000_00FE_0000_0001, "R2 stream second value");
        check({63'd0, ovf_pulse}, 64'd1, "R10 stream second ovf");
        @(negedge clk);
        check({63'd0, out_valid}, 64'd1, "R2 stream third valid");
        check(out_prod, 64'd2, "R2 stream third value");
        check({63'd0, ovf_pulse}, 64'd0, "R10 stream pulse one cycle");
        @(negedge clk);
        check({62'd0, out_valid, ovf_pulse}, 64'd0, "R2 stream drained");
    endtask

    initial begin
        test_reset();
        test_signed();
        test_unsigned();
        test_frac();
        test_stream();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule